// File: doc/BRIEF.md
# External Edge Interrupt Controller

This block watches a set of external input lines and turns selected transitions into latched pending flags and interrupt pulses. The lines are split over two register banks of 32 bits each. Every line has six configuration or status bits: an interrupt enable, an event enable, a rising-edge select, a falling-edge select, a software trigger and a pending flag. Some bit positions are not writable in a given bank; those bits stay 0.

Inputs are synchronised and compared with their previous value. A selected edge on an enabled line sets the pending flag. A software trigger can set the same flag, but only on a 0-to-1 write of the trigger bit. Software clears a flag by writing 1 to it. Clearing the flag also clears the line's software trigger bit.

Line 0 and line 1 of the first bank each drive their own interrupt output. Lines 5 to 9 of that bank share one output. Each output gives a one-cycle pulse when a pending flag goes from 0 to 1, so it behaves as an event toward the downstream interrupt controller. Access is through a simple bus: writes take effect at the clock edge and reads return data in the same cycle.

Top module: `extint_ctrl`

## Requirements
- R1: After reset every register in both banks reads 0 and all three interrupt outputs are 0.
- R2: Registers sit at byte offsets 0x00 enable, 0x04 event enable, 0x08 rising select, 0x0C falling select, 0x10 software trigger, 0x14 pending. The second bank repeats this order at 0x20. Every other address reads 0, and a write to it changes no register.
- R3: In the first bank, both enable registers take all 32 bits. The rising select, falling select, software trigger and pending registers take only the bits in 0x007DFFFF. All other bits read 0.
- R4: In the second bank, both enable registers take only the bits in 0x000000FF. The other four registers take only the bits in 0x00000078. All other bits read 0.
- R5: An input passes two synchroniser flops and one history flop. Its pending flag reads 1 after the third rising clock edge that follows the input change. Rising select alone latches only 0-to-1 changes and falling select alone latches only 1-to-0 changes. Both selects latch either direction, and with neither select nothing is latched.
- R6: A bus write that takes a software trigger bit from 0 to 1 while the line is enabled sets the pending flag at that clock edge, and the trigger bit reads back 1. Writing 1 over a trigger bit that is already 1 sets nothing.
- R7: A hardware edge or software trigger on a line whose enable bit is 0 is dropped. Setting the enable bit later does not set the pending flag.
- R8: Writing 1 to a pending bit clears that bit and the matching software trigger bit. Writing 0 to a pending bit has no effect.
- R9: If an edge sets a pending flag in the same cycle that a bus write clears it, the flag stays 1.
- R10: The line 0 and line 1 outputs pulse high for exactly one cycle, in the cycle the matching pending flag first reads 1. Clearing the flag later produces no further pulse.
- R11: A new pending flag on any of lines 5 to 9 pulses the shared group output for one cycle. The pending register still shows only the bit of the line that fired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| lines_a_i | input | 32 | External lines of the first bank |
| lines_b_i | input | 32 | External lines of the second bank |
| irq_line0_o | output | 1 | Event pulse for line 0 |
| irq_line1_o | output | 1 | Event pulse for line 1 |
| irq_grp_o | output | 1 | Shared event pulse for lines 5 to 9 |

## Verification
The bench builds the block with its default parameters: an 8-bit address, the two write-mask pairs shown in R3 and R4, and the group spanning lines 5 to 9. With these values, writes of all ones show the unwritable holes in both banks. Lines 0, 1 and 5 to 9 can be driven against their own outputs, and bank-two line 3 can be driven through its software trigger. Random writes to the configuration registers are checked against a bench model of the masks. Directed sequences then cover the edge selections, masked drops, the software-trigger rules and the same-cycle set/clear race.

// File: rtl/extint_pkg.sv
package extint_pkg;

  localparam int REG_W = 32;
  localparam int IDX_W = 3;

  localparam logic [IDX_W-1:0] IX_IMASK  = 3'd0;
  localparam logic [IDX_W-1:0] IX_EMASK  = 3'd1;
  localparam logic [IDX_W-1:0] IX_RISE   = 3'd2;
  localparam logic [IDX_W-1:0] IX_FALL   = 3'd3;
  localparam logic [IDX_W-1:0] IX_SWTRIG = 3'd4;
  localparam logic [IDX_W-1:0] IX_PEND   = 3'd5;

  // Lines whose selected edge was seen and whose enable is on.
  function automatic logic [REG_W-1:0] edge_hit(
    input logic [REG_W-1:0] rise, input logic [REG_W-1:0] fall,
    input logic [REG_W-1:0] rsel, input logic [REG_W-1:0] fsel,
    input logic [REG_W-1:0] en);
    return ((rise & rsel) | (fall & fsel)) & en;
  endfunction

  // Software trigger bits going 0 -> 1 on enabled lines.
  function automatic logic [REG_W-1:0] sw_fire(
    input logic [REG_W-1:0] old_v, input logic [REG_W-1:0] new_v,
    input logic [REG_W-1:0] en);
    return new_v & ~old_v & en;
  endfunction

  // Next pending state; a set wins over a clear.
  function automatic logic [REG_W-1:0] pend_next(
    input logic [REG_W-1:0] cur, input logic [REG_W-1:0] set_v,
    input logic [REG_W-1:0] clr_v);
    return (cur & ~clr_v) | set_v;
  endfunction

endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] meta_q, sync_q, hist_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      hist_q <= '0;
    end else begin
      meta_q <= raw_i;
      sync_q <= meta_q;
      hist_q <= sync_q;
    end
  end

  assign rise_o = sync_q & ~hist_q;
  assign fall_o = ~sync_q & hist_q;
endmodule

// File: rtl/extint_bank.sv
module extint_bank import extint_pkg::*; #(
  parameter logic [REG_W-1:0] MASK_WR = '1,
  parameter logic [REG_W-1:0] TRIG_WR = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [REG_W-1:0] wdata,
  input  logic [REG_W-1:0] rise_i,
  input  logic [REG_W-1:0] fall_i,
  output logic [REG_W-1:0] rdata_o,
  output logic [REG_W-1:0] imask_o,
  output logic [REG_W-1:0] emask_o,
  output logic [REG_W-1:0] rsel_o,
  output logic [REG_W-1:0] fsel_o,
  output logic [REG_W-1:0] swtrig_o,
  output logic [REG_W-1:0] pend_o,
  output logic [REG_W-1:0] set_o,
  output logic [REG_W-1:0] clr_o,
  output logic [REG_W-1:0] newp_o
);
  logic [REG_W-1:0] imask_q, emask_q, rsel_q, fsel_q, swtrig_q, pend_q, newp_q;
  logic [REG_W-1:0] wv, swtrig_d, fire;
  logic             is_mask;

  always_comb begin
    is_mask  = (idx == IX_IMASK) || (idx == IX_EMASK);
    wv       = wdata & (is_mask ? MASK_WR : TRIG_WR);
    fire     = '0;
    clr_o    = '0;
    swtrig_d = swtrig_q;
    if (wr_en && idx == IX_SWTRIG) begin
      fire     = sw_fire(swtrig_q, wv, imask_q);
      swtrig_d = wv;
    end
    if (wr_en && idx == IX_PEND) begin
      clr_o    = wv;
      swtrig_d = swtrig_q & ~wv;
    end
    set_o = edge_hit(rise_i, fall_i, rsel_q, fsel_q, imask_q) | fire;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      imask_q  <= '0;
      emask_q  <= '0;
      rsel_q   <= '0;
      fsel_q   <= '0;
      swtrig_q <= '0;
      pend_q   <= '0;
      newp_q   <= '0;
    end else begin
      if (wr_en && idx == IX_IMASK) imask_q <= wv;
      if (wr_en && idx == IX_EMASK) emask_q <= wv;
      if (wr_en && idx == IX_RISE)  rsel_q  <= wv;
      if (wr_en && idx == IX_FALL)  fsel_q  <= wv;
      swtrig_q <= swtrig_d;
      pend_q   <= pend_next(pend_q, set_o, clr_o);
      newp_q   <= set_o & ~pend_q;
    end
  end

  always_comb begin
    case (idx)
      IX_IMASK:  rdata_o = imask_q;
      IX_EMASK:  rdata_o = emask_q;
      IX_RISE:   rdata_o = rsel_q;
      IX_FALL:   rdata_o = fsel_q;
      IX_SWTRIG: rdata_o = swtrig_q;
      IX_PEND:   rdata_o = pend_q;
      default:   rdata_o = '0;
    endcase
  end

  assign imask_o  = imask_q;
  assign emask_o  = emask_q;
  assign rsel_o   = rsel_q;
  assign fsel_o   = fsel_q;
  assign swtrig_o = swtrig_q;
  assign pend_o   = pend_q;
  assign newp_o   = newp_q;
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl import extint_pkg::*; #(
  parameter int               ADDR_W    = 8,
  parameter logic [REG_W-1:0] A_MASK_WR = 32'hFFFF_FFFF,
  parameter logic [REG_W-1:0] A_TRIG_WR = 32'h007D_FFFF,
  parameter logic [REG_W-1:0] B_MASK_WR = 32'h0000_00FF,
  parameter logic [REG_W-1:0] B_TRIG_WR = 32'h0000_0078,
  parameter int               GRP_LO    = 5,
  parameter int               GRP_HI    = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic [REG_W-1:0]  lines_a_i,
  input  logic [REG_W-1:0]  lines_b_i,
  output logic              irq_line0_o,
  output logic              irq_line1_o,
  output logic              irq_grp_o
);
  localparam int BANKS    = 2;
  localparam int IDX_LSB  = 2;
  localparam int BANK_BIT = IDX_LSB + IDX_W;
  localparam int TOP_LSB  = BANK_BIT + 1;

  logic [BANKS-1:0][REG_W-1:0] lines, rise, fall, rd;
  logic [BANKS-1:0][REG_W-1:0] imask, emask, rsel, fsel, swtrig, pend, setv, clrv, newp;
  logic [BANKS-1:0]            wr_hit;
  logic [IDX_W-1:0]            idx;
  logic                        addr_ok, bank_b;

  assign lines   = {lines_b_i, lines_a_i};
  assign idx     = bus_addr[BANK_BIT-1:IDX_LSB];
  assign bank_b  = bus_addr[BANK_BIT];
  assign addr_ok = (bus_addr[IDX_LSB-1:0] == '0) &&
                   (bus_addr[ADDR_W-1:TOP_LSB] == '0) && (idx <= IX_PEND);

  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    localparam logic [REG_W-1:0] MW = (g == 0) ? A_MASK_WR : B_MASK_WR;
    localparam logic [REG_W-1:0] TW = (g == 0) ? A_TRIG_WR : B_TRIG_WR;

    assign wr_hit[g] = bus_sel && bus_wr && addr_ok && (bank_b == (g != 0));

    extint_sync #(.W(REG_W)) u_sync (
      .clk(clk), .rst_n(rst_n), .raw_i(lines[g]),
      .rise_o(rise[g]), .fall_o(fall[g])
    );

    extint_bank #(.MASK_WR(MW), .TRIG_WR(TW)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_hit[g]), .idx(idx),
      .wdata(bus_wdata), .rise_i(rise[g]), .fall_i(fall[g]),
      .rdata_o(rd[g]), .imask_o(imask[g]), .emask_o(emask[g]),
      .rsel_o(rsel[g]), .fsel_o(fsel[g]), .swtrig_o(swtrig[g]),
      .pend_o(pend[g]), .set_o(setv[g]), .clr_o(clrv[g]), .newp_o(newp[g])
    );
  end

  assign bus_rdata   = addr_ok ? rd[bank_b] : '0;
  assign irq_line0_o = newp[0][0];
  assign irq_line1_o = newp[0][1];
  assign irq_grp_o   = |newp[0][GRP_HI:GRP_LO];
endmodule

// File: rtl/extint_ctrl_chk.sv
module extint_ctrl_chk #(
  parameter logic [31:0] A_MASK = 32'hFFFF_FFFF,
  parameter logic [31:0] A_TRIG = 32'h007D_FFFF,
  parameter logic [31:0] B_MASK = 32'h0000_00FF,
  parameter logic [31:0] B_TRIG = 32'h0000_0078,
  parameter int          GRP_LO = 5,
  parameter int          GRP_HI = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0][31:0] imask,
  input logic [1:0][31:0] emask,
  input logic [1:0][31:0] rsel,
  input logic [1:0][31:0] fsel,
  input logic [1:0][31:0] swtrig,
  input logic [1:0][31:0] pend,
  input logic [1:0][31:0] setv,
  input logic [1:0][31:0] clrv,
  input logic [1:0][31:0] newp,
  input logic             irq_line0_o,
  input logic             irq_grp_o
);
  p_bits_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (((imask[0] | emask[0]) & ~A_MASK) == '0) &&
    (((rsel[0] | fsel[0] | swtrig[0] | pend[0]) & ~A_TRIG) == '0));

  p_bits_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (((imask[1] | emask[1]) & ~B_MASK) == '0) &&
    (((rsel[1] | fsel[1] | swtrig[1] | pend[1]) & ~B_TRIG) == '0));

  p_masked_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & ~$past(pend) & ~$past(imask)) == '0);

  p_clr_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((clrv & ~setv) != '0) |=> ((pend & $past(clrv & ~setv)) == '0));

  p_clr_sw_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clrv != '0) |=> ((swtrig & $past(clrv)) == '0));

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (setv != '0) |=> ((pend & $past(setv)) == $past(setv)));

  p_newp_pend_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (newp & ~pend) == '0);

  p_pulse_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_line0_o |=> !irq_line0_o);

  p_grp_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_grp_o |-> (pend[0][GRP_HI:GRP_LO] != '0));
endmodule

bind extint_ctrl extint_ctrl_chk #(
  .A_MASK(A_MASK_WR), .A_TRIG(A_TRIG_WR), .B_MASK(B_MASK_WR),
  .B_TRIG(B_TRIG_WR), .GRP_LO(GRP_LO), .GRP_HI(GRP_HI)
) u_chk (
  .clk(clk), .rst_n(rst_n), .imask(imask), .emask(emask), .rsel(rsel),
  .fsel(fsel), .swtrig(swtrig), .pend(pend), .setv(setv), .clrv(clrv),
  .newp(newp), .irq_line0_o(irq_line0_o), .irq_grp_o(irq_grp_o)
);

// File: tb/extint_ctrl_tb.sv
module extint_ctrl_tb;
  logic        clk = 0, rst_n = 0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [31:0] lines_a_i = '0, lines_b_i = '0;
  logic        irq_line0_o, irq_line1_o, irq_grp_o;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  extint_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lines_a_i(lines_a_i), .lines_b_i(lines_b_i),
    .irq_line0_o(irq_line0_o), .irq_line1_o(irq_line1_o), .irq_grp_o(irq_grp_o)
  );

  // Bench model of the writable bits (R3, R4).
  function automatic logic [31:0] wmask(input int b, input int ix);
    if (ix < 2) return (b == 0) ? 32'hFFFF_FFFF : 32'h0000_00FF;
    return (b == 0) ? 32'h007D_FFFF : 32'h0000_0078;
  endfunction

  function automatic logic [7:0] ra(input int b, input int ix);
    return 8'(b * 32 + ix * 4);
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic chk_rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  // Three edges through sync, history and pending register (R5).
  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h1357_2468));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R1: reset state
    for (int b = 0; b < 2; b++)
      for (int ix = 0; ix < 6; ix++) chk_rd("R1 reg", ra(b, ix), 32'h0);
    chk("R1 irq", {29'h0, irq_line0_o, irq_line1_o, irq_grp_o}, 32'h0);

    // R3/R4: all-ones writes on configuration registers
    for (int b = 0; b < 2; b++)
      for (int ix = 0; ix < 4; ix++) begin
        wr(ra(b, ix), 32'hFFFF_FFFF);
        chk_rd(b == 0 ? "R3 ones" : "R4 ones", ra(b, ix), wmask(b, ix));
        wr(ra(b, ix), 32'h0);
      end
    for (int b = 0; b < 2; b++) begin
      wr(ra(b, 4), 32'hFFFF_FFFF);  // enables are 0: no pending (R7)
      chk_rd(b == 0 ? "R3 swtrig" : "R4 swtrig", ra(b, 4), wmask(b, 4));
      chk_rd("R7 no pend", ra(b, 5), 32'h0);
      wr(ra(b, 4), 32'h0);
      wr(ra(b, 5), 32'hFFFF_FFFF);
      chk_rd(b == 0 ? "R3 pend" : "R4 pend", ra(b, 5), 32'h0);
    end

    // R3/R4 random configuration writes against the mask model
    for (int i = 0; i < 60; i++) begin
      int b, ix;
      logic [31:0] v;
      b = int'($urandom_range(1, 0));
      ix = int'($urandom_range(3, 0));
      v = $urandom;
      wr(ra(b, ix), v);
      chk_rd(b == 0 ? "R3 random" : "R4 random", ra(b, ix), v & wmask(b, ix));
    end
    for (int b = 0; b < 2; b++)
      for (int ix = 0; ix < 4; ix++) wr(ra(b, ix), 32'h0);
    chk_rd("R7 random no pend", ra(0, 5), 32'h0);

    // R2: unmapped and misaligned addresses
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h01, 32'hFFFF_FFFF);
    chk_rd("R2 hole 0x18", 8'h18, 32'h0);
    chk_rd("R2 hole 0x40", 8'h40, 32'h0);
    chk_rd("R2 no alias 0x00", 8'h00, 32'h0);
    wr(8'h20, 32'h0000_00A5);
    chk_rd("R2 bank2 enable", 8'h20, 32'h0000_00A5);
    chk_rd("R2 bank1 enable", 8'h00, 32'h0);
    wr(8'h20, 32'h0);

    // R5/R10: rising only on line 0
    wr(8'h00, 32'h1); wr(8'h08, 32'h1);
    lines_a_i[0] = 1; settle();
    chk_rd("R5 rise pend", 8'h14, 32'h1);
    chk("R10 irq0 pulse", {31'h0, irq_line0_o}, 32'h1);
    chk("R10 irq1 quiet", {31'h0, irq_line1_o}, 32'h0);
    @(negedge clk);
    chk("R10 irq0 one cycle", {31'h0, irq_line0_o}, 32'h0);
    wr(8'h14, 32'h0);
    chk_rd("R8 write 0 no effect", 8'h14, 32'h1);
    wr(8'h14, 32'h1);
    chk_rd("R8 clear", 8'h14, 32'h0);
    chk("R10 no pulse on clear", {31'h0, irq_line0_o}, 32'h0);
    lines_a_i[0] = 0; settle();
    chk_rd("R5 fall ignored", 8'h14, 32'h0);

    // R5: falling only
    wr(8'h08, 32'h0); wr(8'h0C, 32'h1);
    lines_a_i[0] = 1; settle();
    chk_rd("R5 rise ignored", 8'h14, 32'h0);
    lines_a_i[0] = 0; settle();
    chk_rd("R5 fall pend", 8'h14, 32'h1);
    chk("R10 irq0 fall", {31'h0, irq_line0_o}, 32'h1);
    wr(8'h14, 32'h1);

    // R5: both edges
    wr(8'h08, 32'h1);
    lines_a_i[0] = 1; settle();
    chk_rd("R5 both rise", 8'h14, 32'h1);
    wr(8'h14, 32'h1);
    lines_a_i[0] = 0; settle();
    chk_rd("R5 both fall", 8'h14, 32'h1);
    wr(8'h14, 32'h1);

    // R5: neither
    wr(8'h08, 32'h0); wr(8'h0C, 32'h0);
    lines_a_i[0] = 1; settle();
    chk_rd("R5 none rise", 8'h14, 32'h0);
    lines_a_i[0] = 0; settle();
    chk_rd("R5 none fall", 8'h14, 32'h0);
    chk("R5 none irq", {31'h0, irq_line0_o}, 32'h0);

    // R9: set and clear in the same cycle on line 1
    wr(8'h00, 32'h2); wr(8'h08, 32'h2);
    lines_a_i[1] = 1; settle();
    chk_rd("R9 first set", 8'h14, 32'h2);
    chk("R10 irq1 pulse", {31'h0, irq_line1_o}, 32'h1);
    lines_a_i[1] = 0; settle();
    lines_a_i[1] = 1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    wr(8'h14, 32'h2);
    chk_rd("R9 set wins", 8'h14, 32'h2);
    chk("R9 no new pulse", {31'h0, irq_line1_o}, 32'h0);
    wr(8'h14, 32'h2);
    chk_rd("R8 clear line1", 8'h14, 32'h0);
    lines_a_i[1] = 0; settle();

    // R6/R8: software trigger on line 0
    wr(8'h00, 32'h1);
    wr(8'h10, 32'h0); wr(8'h10, 32'h1);
    chk_rd("R6 sw readback", 8'h10, 32'h1);
    chk_rd("R6 sw pend", 8'h14, 32'h1);
    chk("R6 sw irq0", {31'h0, irq_line0_o}, 32'h1);
    wr(8'h14, 32'h1);
    chk_rd("R8 pend cleared", 8'h14, 32'h0);
    chk_rd("R8 sw cleared", 8'h10, 32'h0);

    // R7/R6: masked software trigger, then rewrite of 1 over 1
    wr(8'h00, 32'h0);
    wr(8'h10, 32'h1);
    chk_rd("R7 sw stored", 8'h10, 32'h1);
    chk_rd("R7 sw masked", 8'h14, 32'h0);
    wr(8'h00, 32'h1);
    chk_rd("R7 late enable", 8'h14, 32'h0);
    wr(8'h10, 32'h1);
    chk_rd("R6 one over one", 8'h14, 32'h0);
    chk("R6 no irq", {31'h0, irq_line0_o}, 32'h0);
    wr(8'h10, 32'h0); wr(8'h00, 32'h0);

    // R6/R8 in bank two, line 3
    wr(8'h20, 32'h8);
    wr(8'h30, 32'h0); wr(8'h30, 32'h8);
    chk_rd("R6 bank2 sw", 8'h30, 32'h8);
    chk_rd("R6 bank2 pend", 8'h34, 32'h8);
    wr(8'h34, 32'h8);
    chk_rd("R8 bank2 pend clr", 8'h34, 32'h0);
    chk_rd("R8 bank2 sw clr", 8'h30, 32'h0);
    wr(8'h20, 32'h0);

    // R7: masked hardware edge on line 1
    wr(8'h00, 32'h0); wr(8'h08, 32'h2);
    lines_a_i[1] = 1; settle();
    chk_rd("R7 hw masked", 8'h14, 32'h0);
    chk("R7 irq1 quiet", {31'h0, irq_line1_o}, 32'h0);
    wr(8'h00, 32'h2);
    chk_rd("R7 hw late enable", 8'h14, 32'h0);
    wr(8'h00, 32'h0); wr(8'h08, 32'h0);
    lines_a_i[1] = 0; settle();

    // R11: shared output for lines 5 to 9
    wr(8'h00, 32'h0000_03E0); wr(8'h08, 32'h0000_03E0);
    for (int i = 5; i < 10; i++) begin
      lines_a_i[i] = 1; settle();
      chk_rd("R11 pend one line", 8'h14, 32'h1 << i);
      chk("R11 grp pulse", {31'h0, irq_grp_o}, 32'h1);
      chk("R11 line0 quiet", {31'h0, irq_line0_o}, 32'h0);
      @(negedge clk);
      chk("R11 grp one cycle", {31'h0, irq_grp_o}, 32'h0);
      wr(8'h14, 32'h1 << i);
      chk_rd("R11 cleared", 8'h14, 32'h0);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule